// File: doc/BRIEF.md
# Halfword Packing Burst Writer

This block takes a stream of 16-bit values on a valid/ready input and writes them to memory through the write channels of a 32-bit AXI4 port. Pairs of halfwords are joined into full 32-bit beats and parked in a small beat queue. A write burst is only launched once a threshold number of beats is waiting, so the bus sees long, full-width transfers rather than one transaction per halfword. Every burst uses the full 4-byte beat size. Narrower transfer sizes are never issued.

The destination may start on any 2-byte boundary. When the start is not 4-byte aligned, the first halfword is placed in the upper lane of the first beat and the lower lane is masked off with the byte strobes. A flush request drains everything that is queued as a final, shorter burst. If one halfword is left over at that point, it goes in the lower lane with the upper lane masked. Only one burst is outstanding at a time. A response other than OKAY latches an error flag.

Top module: `halfword_burst_writer`

## Requirements
- R1: Two successive accepted halfwords form one beat: the earlier one in WDATA[15:0], the later one in WDATA[31:16], with WSTRB = 4'b1111.
- R2: Every address request carries AWSIZE = 3'b010 (4 bytes per beat) and AWBURST = 2'b01 (incrementing).
- R3: AWLEN equals the number of beats in the burst minus one. WLAST is high on the beat numbered AWLEN and on no other beat. The address request holds steady while it waits for AWREADY.
- R4: After a load with cfg_haddr bit 1 set, the first beat carries the first halfword in WDATA[31:16], zero in WDATA[15:0], and WSTRB = 4'b1100. The first burst address is the loaded address with its two low bits cleared.
- R5: A flush pulse drains all queued data. A leftover single halfword is sent in WDATA[15:0] with WSTRB = 4'b0011 and zero in the upper lane. Afterwards, packing resumes in the lower lane of the next word address.
- R6: Outside a flush, a burst starts only when at least THRESH beats are queued, and it is THRESH beats long unless R8 shortens it.
- R7: AWADDR always has its two low bits at zero. Each burst starts 4 × (beats of the previous burst) bytes after the previous burst.
- R8: No burst crosses a 4096-byte boundary. Its length is the smallest of the queued beats, THRESH, and the words left in the current 4 KB page.
- R9: AWVALID is not raised for a new burst until the write response of the previous burst has been accepted.
- R10: A write response with BRESP other than 2'b00 sets err, and err stays set until reset.
- R11: in_ready is low while the beat queue is full or a flush is in progress. No accepted halfword is lost or duplicated.
- R12: After reset, awvalid, wvalid, bready and err are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Loads the start halfword address (used while idle) |
| cfg_haddr | input | 31 | Start byte address bits 31:1 (halfword aligned) |
| flush | input | 1 | Pulse: send all buffered data as a final burst |
| in_valid | input | 1 | Input halfword valid |
| in_data | input | 16 | Input halfword |
| in_ready | output | 1 | Input halfword accepted when high with in_valid |
| awaddr | output | 32 | Burst start address |
| awlen | output | 8 | Beats minus one |
| awsize | output | 3 | Beat size code, always 4 bytes |
| awburst | output | 2 | Burst type, always incrementing |
| awvalid | output | 1 | Address request valid |
| awready | input | 1 | Address request accepted |
| wdata | output | 32 | Write beat data |
| wstrb | output | 4 | Byte lane enables |
| wlast | output | 1 | Final beat of burst |
| wvalid | output | 1 | Write beat valid |
| wready | input | 1 | Write beat accepted |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response accepted |
| err | output | 1 | Sticky error from a non-OKAY response |

## Verification
The bench builds the block with THRESH = 4 and DEPTH = 8. With these values, every halfword count from 1 to 20 spans from a sub-beat flush to several full bursts plus a remainder, for both an aligned and a halfword-offset start. The small queue makes a full queue easy to reach by holding WREADY low, which puts input back-pressure within reach. A start two words below a page edge forces a clamped two-beat burst. A continuation without reload checks how packing resumes after an odd flush.

// File: rtl/hwbw_pkg.sv
package hwbw_pkg;

    localparam logic [2:0] AXSIZE_WORD = 3'b010;
    localparam logic [1:0] BURST_INCR  = 2'b01;
    localparam logic [1:0] RESP_OKAY   = 2'b00;

    localparam logic [3:0] STRB_FULL  = 4'b1111;
    localparam logic [3:0] STRB_UPPER = 4'b1100;
    localparam logic [3:0] STRB_LOWER = 4'b0011;

    localparam int unsigned PAGE_WORDS = 1024;

    typedef struct packed {
        logic [31:0] data;
        logic [3:0]  strb;
    } beat_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_RESP
    } burst_state_e;

    function automatic int unsigned min3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b < m) m = b;
        if (c < m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/hwbw_packer.sv
module hwbw_packer
    import hwbw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic        upper_first,
    input  logic        in_valid,
    input  logic [15:0] in_data,
    input  logic        fifo_full,
    input  logic        flush_pend,
    output logic        in_ready,
    output logic        push,
    output beat_t       push_beat,
    output logic        pend_empty
);

    logic        upper_next;
    logic        have_lo;
    logic [15:0] lo_q;
    logic        take;
    logic        pad;

    assign in_ready   = !fifo_full && !flush_pend;
    assign pend_empty = !have_lo;
    assign take       = in_valid && in_ready;
    assign pad        = flush_pend && have_lo && !fifo_full;

    always_comb begin
        push      = 1'b0;
        push_beat = '{data: '0, strb: '0};
        if (pad) begin
            push           = 1'b1;
            push_beat.data = {16'h0000, lo_q};
            push_beat.strb = STRB_LOWER;
        end else if (take && upper_next) begin
            push           = 1'b1;
            push_beat.data = {in_data, 16'h0000};
            push_beat.strb = STRB_UPPER;
        end else if (take && have_lo) begin
            push           = 1'b1;
            push_beat.data = {in_data, lo_q};
            push_beat.strb = STRB_FULL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_next <= 1'b0;
            have_lo    <= 1'b0;
            lo_q       <= '0;
        end else if (load) begin
            upper_next <= upper_first;
            have_lo    <= 1'b0;
        end else if (pad) begin
            have_lo <= 1'b0;
        end else if (take) begin
            if (upper_next) begin
                upper_next <= 1'b0;
            end else begin
                have_lo <= !have_lo;
                if (!have_lo) lo_q <= in_data;
            end
        end
    end

endmodule

// File: rtl/hwbw_fifo.sv
module hwbw_fifo
    import hwbw_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  beat_t             push_beat,
    input  logic              pop,
    output beat_t             head,
    output logic              full,
    output logic [$clog2(DEPTH):0] count
);

    localparam int PW = $clog2(DEPTH);

    beat_t         mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign full    = (count == (PW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_beat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/hwbw_burst_ctl.sv
module hwbw_burst_ctl
    import hwbw_pkg::*;
#(
    parameter int THRESH = 16,
    parameter int CW     = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [29:0]   load_word,
    input  logic [CW-1:0] count,
    input  beat_t         head,
    input  logic          flush_go,
    output logic          pop,
    output logic          flush_done,
    output logic [31:0]   awaddr,
    output logic [7:0]    awlen,
    output logic [2:0]    awsize,
    output logic [1:0]    awburst,
    output logic          awvalid,
    input  logic          awready,
    output logic [31:0]   wdata,
    output logic [3:0]    wstrb,
    output logic          wlast,
    output logic          wvalid,
    input  logic          wready,
    input  logic [1:0]    bresp,
    input  logic          bvalid,
    output logic          bready,
    output logic          err
);

    burst_state_e state;
    logic [29:0]  addr_q;
    logic [7:0]   len_q;
    logic [7:0]   beat_q;
    int unsigned  room_w;
    int unsigned  n_beats;
    logic         start;

    assign room_w  = PAGE_WORDS - 32'(addr_q[9:0]);
    assign n_beats = min3(32'(count), 32'(THRESH), room_w);
    assign start   = !load && (state == ST_IDLE) &&
                     ((count >= CW'(THRESH)) || (flush_go && count != '0));
    assign flush_done = (state == ST_IDLE) && flush_go && (count == '0);

    assign awaddr  = {addr_q, 2'b00};
    assign awlen   = len_q;
    assign awsize  = AXSIZE_WORD;
    assign awburst = BURST_INCR;
    assign awvalid = (state == ST_ADDR);
    assign wvalid  = (state == ST_DATA);
    assign wdata   = head.data;
    assign wstrb   = head.strb;
    assign wlast   = wvalid && (beat_q == len_q);
    assign bready  = (state == ST_RESP);
    assign pop     = wvalid && wready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            len_q  <= '0;
            beat_q <= '0;
            err    <= 1'b0;
        end else begin
            if (load && state == ST_IDLE) addr_q <= load_word;
            case (state)
                ST_IDLE: if (start) begin
                    len_q  <= 8'(n_beats - 1);
                    beat_q <= '0;
                    state  <= ST_ADDR;
                end
                ST_ADDR: if (awready) begin
                    addr_q <= addr_q + 30'(32'(len_q) + 1);
                    state  <= ST_DATA;
                end
                ST_DATA: if (wready) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == len_q) state <= ST_RESP;
                end
                ST_RESP: if (bvalid) begin
                    if (bresp != RESP_OKAY) err <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/halfword_burst_writer.sv
module halfword_burst_writer
    import hwbw_pkg::*;
#(
    parameter int THRESH = 16,
    parameter int DEPTH  = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_load,
    input  logic [31:1] cfg_haddr,
    input  logic        flush,
    input  logic        in_valid,
    input  logic [15:0] in_data,
    output logic        in_ready,
    output logic [31:0] awaddr,
    output logic [7:0]  awlen,
    output logic [2:0]  awsize,
    output logic [1:0]  awburst,
    output logic        awvalid,
    input  logic        awready,
    output logic [31:0] wdata,
    output logic [3:0]  wstrb,
    output logic        wlast,
    output logic        wvalid,
    input  logic        wready,
    input  logic [1:0]  bresp,
    input  logic        bvalid,
    output logic        bready,
    output logic        err
);

    localparam int CW = $clog2(DEPTH) + 1;

    logic          flush_pend;
    logic          flush_done;
    logic          pend_empty;
    logic          push;
    logic          pop;
    logic          full;
    beat_t         push_beat;
    beat_t         head;
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst)             flush_pend <= 1'b0;
        else if (flush)      flush_pend <= 1'b1;
        else if (flush_done) flush_pend <= 1'b0;
    end

    hwbw_packer u_pack (
        .clk        (clk),
        .rst        (rst),
        .load       (cfg_load),
        .upper_first(cfg_haddr[1]),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .fifo_full  (full),
        .flush_pend (flush_pend),
        .in_ready   (in_ready),
        .push       (push),
        .push_beat  (push_beat),
        .pend_empty (pend_empty)
    );

    hwbw_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_beat(push_beat),
        .pop      (pop),
        .head     (head),
        .full     (full),
        .count    (count)
    );

    hwbw_burst_ctl #(.THRESH(THRESH), .CW(CW)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .load      (cfg_load),
        .load_word (cfg_haddr[31:2]),
        .count     (count),
        .head      (head),
        .flush_go  (flush_pend && pend_empty),
        .pop       (pop),
        .flush_done(flush_done),
        .awaddr    (awaddr),
        .awlen     (awlen),
        .awsize    (awsize),
        .awburst   (awburst),
        .awvalid   (awvalid),
        .awready   (awready),
        .wdata     (wdata),
        .wstrb     (wstrb),
        .wlast     (wlast),
        .wvalid    (wvalid),
        .wready    (wready),
        .bresp     (bresp),
        .bvalid    (bvalid),
        .bready    (bready),
        .err       (err)
    );

endmodule

// File: rtl/hwbw_checker.sv
module hwbw_checker
    import hwbw_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] awaddr,
    input logic [7:0]  awlen,
    input logic [2:0]  awsize,
    input logic [1:0]  awburst,
    input logic        awvalid,
    input logic        awready,
    input logic [3:0]  wstrb,
    input logic        wlast,
    input logic        wvalid,
    input logic        wready,
    input logic [1:0]  bresp,
    input logic        bvalid,
    input logic        bready,
    input logic        err
);

    logic       outstanding;
    logic [7:0] beat_cnt;
    logic [7:0] len_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= 1'b0;
            beat_cnt    <= '0;
            len_seen    <= '0;
        end else begin
            if (awvalid && awready) begin
                outstanding <= 1'b1;
                len_seen    <= awlen;
            end else if (bvalid && bready) begin
                outstanding <= 1'b0;
            end
            if (wvalid && wready) beat_cnt <= wlast ? 8'd0 : beat_cnt + 1'b1;
        end
    end

    AST_SIZE_WORD: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> (awsize == AXSIZE_WORD && awburst == BURST_INCR)); // R2
    AST_AW_HOLD: assert property (@(posedge clk) disable iff (rst)
        awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen)); // R3
    AST_WLAST_AT_LEN: assert property (@(posedge clk) disable iff (rst)
        wvalid |-> (wlast == (beat_cnt == len_seen))); // R3
    AST_STRB_LEGAL: assert property (@(posedge clk) disable iff (rst)
        wvalid |-> (wstrb == STRB_FULL || wstrb == STRB_UPPER || wstrb == STRB_LOWER)); // R4
    AST_ADDR_WORD: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> awaddr[1:0] == 2'b00); // R7
    AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> ({1'b0, awaddr[11:2]} + 11'(awlen)) < 11'd1024); // R8
    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        awvalid |-> !outstanding); // R9
    AST_ERR_ON_BAD_RESP: assert property (@(posedge clk) disable iff (rst)
        bvalid && bready && bresp != RESP_OKAY |=> err); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R10

endmodule

bind halfword_burst_writer hwbw_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .awaddr (awaddr),
    .awlen  (awlen),
    .awsize (awsize),
    .awburst(awburst),
    .awvalid(awvalid),
    .awready(awready),
    .wstrb  (wstrb),
    .wlast  (wlast),
    .wvalid (wvalid),
    .wready (wready),
    .bresp  (bresp),
    .bvalid (bvalid),
    .bready (bready),
    .err    (err)
);

// File: tb/halfword_burst_writer_test.sv
`timescale 1ns/1ps
module halfword_burst_writer_test;

    localparam int THRESH = 4;
    localparam int DEPTH  = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_load = 1'b0;
    logic [31:1] cfg_haddr = '0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready;
    logic [31:0] awaddr;
    logic [7:0]  awlen;
    logic [2:0]  awsize;
    logic [1:0]  awburst;
    logic        awvalid;
    logic        awready = 1'b0;
    logic [31:0] wdata;
    logic [3:0]  wstrb;
    logic        wlast;
    logic        wvalid;
    logic        wready = 1'b0;
    logic [1:0]  bresp = 2'b00;
    logic        bvalid = 1'b0;
    logic        bready;
    logic        err;

    always #2 clk = ~clk;

    halfword_burst_writer #(.THRESH(THRESH), .DEPTH(DEPTH)) uut (.*);

    int checks = 0;
    int errors = 0;

    logic [31:0] cap_aw_addr [0:255];
    logic [7:0]  cap_aw_len  [0:255];
    logic [2:0]  cap_aw_size [0:255];
    logic [1:0]  cap_aw_burst[0:255];
    logic [31:0] cap_w_data  [0:1023];
    logic [3:0]  cap_w_strb  [0:1023];
    logic        cap_w_last  [0:1023];
    int  n_aw = 0, n_w = 0, n_b = 0, b_owed = 0, cyc = 0;
    bit  viol_seen = 0, saw_full = 0;
    int  stall_mode = 0;
    bit  stall_w_hold = 0, err_inject = 0;
    int  cur_base = 0, cur_off = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] hv(input int seed, input int k);
        return 16'((seed * 4951 + k * 515 + 165) & 32'hFFFF);
    endfunction

    // Capture of bus activity at the clock edge
    always @(posedge clk) begin
        if (!rst) begin
            int dec;
            dec = 0;
            if (awvalid && awready) begin
                if (n_aw != n_b) viol_seen = 1;
                cap_aw_addr[n_aw % 256]  = awaddr;
                cap_aw_len[n_aw % 256]   = awlen;
                cap_aw_size[n_aw % 256]  = awsize;
                cap_aw_burst[n_aw % 256] = awburst;
                n_aw++;
            end
            if (wvalid && wready) begin
                cap_w_data[n_w % 1024] = wdata;
                cap_w_strb[n_w % 1024] = wstrb;
                cap_w_last[n_w % 1024] = wlast;
                n_w++;
                if (wlast) b_owed++;
            end
            if (bvalid && bready) begin
                n_b++;
                dec = 1;
            end
            b_owed = b_owed - dec;
        end
    end

    // Slave responses driven away from the edge
    always @(negedge clk) begin
        cyc++;
        awready = (stall_mode == 0) ? 1'b1 : (cyc % 3 == 0);
        wready  = stall_w_hold ? 1'b0 : ((stall_mode == 0) ? 1'b1 : (cyc % 2 == 1));
        bvalid  = (b_owed > 0);
        bresp   = err_inject ? 2'b10 : 2'b00;
        if (in_valid && !in_ready) saw_full = 1;
    end

    task automatic run_seg(input bit do_load, input logic [31:0] addr, input int n,
                           input int seed, input bit hold_w);
        int start_aw, start_w, off, total, rem, a, nb, room, j, waited, nbursts;
        if (do_load) begin
            @(negedge clk);
            cfg_load  = 1'b1;
            cfg_haddr = addr[31:1];
            @(negedge clk);
            cfg_load  = 1'b0;
            cur_base  = int'(addr & 32'hFFFF_FFFC);
            cur_off   = int'(addr[1]);
        end
        start_aw = n_aw;
        start_w  = n_w;
        off      = cur_off;
        total    = (off + n + 1) / 2;
        saw_full = 0;
        if (hold_w) begin
            stall_w_hold = 1;
            fork
                begin
                    repeat (200) @(negedge clk);
                    stall_w_hold = 0;
                end
            join_none
        end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = hv(seed, k);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        flush    = 1'b1;
        @(negedge clk);
        flush    = 1'b0;
        waited = 0;
        while (!((n_w - start_w) >= total && n_b == n_aw && !awvalid && !wvalid && !stall_w_hold)
               && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        repeat (6) @(negedge clk);
        chk((n_w - start_w) == total, "R5 beat count", n_w - start_w, total);
        chk(in_ready == 1'b1, "R11 ready after drain", in_ready, 1);
        chk(!viol_seen, "R9 one outstanding", viol_seen, 0);
        if (hold_w) chk(saw_full, "R11 back-pressure seen", saw_full, 1);
        if ((n_w - start_w) == total) begin
            for (int b = 0; b < total; b++) begin
                logic [31:0] ed;
                logic [3:0]  es;
                int k0, k1;
                k0 = 2 * b - off;
                k1 = 2 * b + 1 - off;
                ed = '0;
                es = '0;
                if (k0 >= 0 && k0 < n) begin ed[15:0]  = hv(seed, k0); es[1:0] = 2'b11; end
                if (k1 >= 0 && k1 < n) begin ed[31:16] = hv(seed, k1); es[3:2] = 2'b11; end
                j = (start_w + b) % 1024;
                if (b == 0 && off == 1) begin
                    chk(cap_w_data[j] == ed, "R4 upper-first data", cap_w_data[j], ed);
                    chk(cap_w_strb[j] == es, "R4 upper-first strobe", cap_w_strb[j], es);
                end else if (es == 4'b0011) begin
                    chk(cap_w_data[j] == ed, "R5 tail data", cap_w_data[j], ed);
                    chk(cap_w_strb[j] == es, "R5 tail strobe", cap_w_strb[j], es);
                end else begin
                    chk(cap_w_data[j] == ed, "R1 packed data", cap_w_data[j], ed);
                    chk(cap_w_strb[j] == es, "R1 packed strobe", cap_w_strb[j], es);
                end
            end
        end
        rem = total;
        a = cur_base;
        j = start_w;
        nbursts = 0;
        while (rem > 0) begin
            int bi;
            room = 1024 - ((a >> 2) & 1023);
            nb = rem;
            if (THRESH < nb) nb = THRESH;
            if (room < nb) nb = room;
            bi = (start_aw + nbursts) % 256;
            if (start_aw + nbursts < n_aw) begin
                chk(cap_aw_addr[bi] == 32'(a), "R7 burst address", cap_aw_addr[bi], a);
                chk(cap_aw_len[bi] == 8'(nb - 1), "R3 awlen", cap_aw_len[bi], nb - 1);
                if (room < THRESH && rem >= THRESH)
                    chk(cap_aw_len[bi] == 8'(nb - 1), "R8 page clamp", cap_aw_len[bi], nb - 1);
                chk(cap_aw_size[bi] == 3'b010 && cap_aw_burst[bi] == 2'b01, "R2 size/burst",
                    {cap_aw_size[bi], cap_aw_burst[bi]}, 5'b01001);
            end
            for (int i = 0; i < nb; i++) begin
                if (j < n_w)
                    chk(cap_w_last[j % 1024] == (i == nb - 1), "R3 wlast",
                        cap_w_last[j % 1024], (i == nb - 1));
                j++;
            end
            a = a + 4 * nb;
            rem = rem - nb;
            nbursts++;
        end
        chk((n_aw - start_aw) == nbursts, "R6 burst count", n_aw - start_aw, nbursts);
        cur_base = a;
        cur_off  = 0;
    endtask

    initial begin
        #(4 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!awvalid && !wvalid && !bready, "R12 bus idle", {awvalid, wvalid, bready}, 0);
        chk(in_ready == 1'b1, "R12 ready", in_ready, 1);
        chk(err == 1'b0, "R12 err clear", err, 0);

        for (int odd = 0; odd < 2; odd++) begin
            for (int n = 1; n <= 20; n++) begin
                stall_mode = n % 2;
                run_seg(1'b1, 32'h0000_0400 + 32'(2 * odd), n, n + 31 * odd, 1'b0);
            end
        end
        stall_mode = 0;
        chk(err == 1'b0, "R10 no error on OKAY", err, 0);

        // R5: odd flush then continue without reload, resume in lower lane
        run_seg(1'b1, 32'h0000_0202, 6, 7, 1'b0);
        run_seg(1'b0, 32'h0, 7, 8, 1'b0);

        // R8: two words left in the page
        run_seg(1'b1, 32'h0000_0FFA, 13, 9, 1'b0);

        // R11: queue fills while the write channel is held
        stall_mode = 1;
        run_seg(1'b1, 32'h0000_0080, 30, 10, 1'b1);
        stall_mode = 0;

        // R10: error response, then stays set across an OKAY burst
        err_inject = 1;
        run_seg(1'b1, 32'h0000_0040, 4, 11, 1'b0);
        err_inject = 0;
        chk(err == 1'b1, "R10 err set", err, 1);
        run_seg(1'b0, 32'h0, 3, 12, 1'b0);
        chk(err == 1'b1, "R10 err sticky", err, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule